// File: doc/BRIEF.md
# Closed-Page DRAM Command Sequencer

This block sits on the controller side of one DRAM rank run under a closed-page policy. It takes access requests (read or write, bank, row, column) through a valid/ready handshake. For each request it drives two commands onto a single shared command bus: a row activate, and later a column command that always carries auto-precharge. Only one command can be on the bus in any clock. A column command that is due always takes the bus, and a new activate waits for the next free clock.

A static mode input picks when the column command fires. In legacy mode it fires a fixed row-to-column delay (`TRCD` clocks) after its activate. Because of this, the activates of later requests can run into earlier column commands and slip further than their requests did. In posted mode the column command fires on the clock right after its activate, and the DRAM adds the extra latency internally. Activates to the same bank are always kept a programmable row-cycle distance apart. With every column command the block also reports how many clocks the first data beat will trail the command.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `cmd_valid` is 0, `cmd_kind` is 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) appears in the next cycle as an activate: `cmd_kind` = 1, with its bank, and with its row on `cmd_addr`.
- R3: With `posted_en` low, the column command of a request appears exactly `TRCD` (default 3) cycles after its activate. It carries the request's bank and its column, zero-extended on `cmd_addr`. `cmd_kind` is 2 for a read and 3 for a write. Column commands come out in acceptance order.
- R4: With `posted_en` high, the column command of a request appears in the cycle right after its activate, with the same fields as in R3.
- R5: At most one command is issued per cycle. `req_ready` is low in any cycle whose following clock edge is taken by a due column command.
- R6: `cmd_autopre` is 1 on every column command and 0 on every activate and idle cycle.
- R7: Two activates to the same bank are at least `trc_cfg` cycles apart (`trc_cfg` >= 1). `req_ready` is low while the requested bank is still inside that window.
- R8: On a read column command, `data_lat` is `CL` (2) in legacy mode and `AL+CL` (4) in posted mode. On a write it is one less. On all other cycles it is 0.
- R9: Under a constant stream of requests to four distinct banks, starting from idle: in legacy mode the activates fall in cycles 1, 2, 3 and 7 after the first request is presented. In posted mode they fall every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| posted_en | input | 1 | 1 = column command right after its activate; held static while busy |
| trc_cfg | input | 6 | Minimum cycles between activates to the same bank |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 14 | Row address |
| req_col | input | 10 | Column address |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_kind | output | 2 | 0 idle, 1 activate, 2 read, 3 write |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | 14 | Row on activate, column on read or write |
| cmd_autopre | output | 1 | Auto-precharge flag |
| data_lat | output | 3 | Clocks from column command to the first data beat |

## Verification
A lost or misplaced entry in the column delay line shows up at the ports within `TRCD` cycles. It appears either as a missing or wrongly timed read/write command, or as `req_ready` staying high in a cycle that should have gone to a column command. A bank window counter that is stuck or was loaded wrong shows up on the next request to that bank, as `req_ready` out of step with a cycle-exact reference model. The bench compares every output in every cycle against that model, so an error shows up in the cycle it first affects the bus.

// File: rtl/ddr_cmd_seq_pkg.sv
package ddr_cmd_seq_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_ACT  = 2'd1,
    KIND_RD   = 2'd2,
    KIND_WR   = 2'd3
  } cmd_kind_e;

  // Clocks from a column command to its first data beat.
  function automatic int unsigned beat_delay(input logic posted, input logic wr,
                                             input int unsigned cl, input int unsigned al);
    int unsigned d;
    d = cl + (posted ? al : 0);
    if (wr) d = d - 1;
    return d;
  endfunction

endpackage

// File: rtl/ddr_cmd_seq_colpipe.sv
// Delay line for pending column commands: entry 0 is issued at the next edge.
module ddr_cmd_seq_colpipe #(
  parameter int DEPTH  = 3,
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [IDX_W-1:0]  ins_at,
  input  logic              ins_write,
  input  logic [BANK_W-1:0] ins_bank,
  input  logic [COL_W-1:0]  ins_col,
  output logic              head_valid,
  output logic              head_write,
  output logic [BANK_W-1:0] head_bank,
  output logic [COL_W-1:0]  head_col
);

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [DEPTH-1:0]  wr_q, wr_d;
  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [BANK_W-1:0] bank_d [DEPTH];
  logic [COL_W-1:0]  col_q  [DEPTH];
  logic [COL_W-1:0]  col_d  [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic hit;
    assign hit = ins_en && (ins_at == IDX_W'(k));

    if (k == DEPTH - 1) begin : g_tail
      always_comb begin
        vld_d[k]  = hit;
        wr_d[k]   = hit ? ins_write : 1'b0;
        bank_d[k] = hit ? ins_bank  : '0;
        col_d[k]  = hit ? ins_col   : '0;
      end
    end else begin : g_mid
      always_comb begin
        vld_d[k]  = hit ? 1'b1      : vld_q[k+1];
        wr_d[k]   = hit ? ins_write : wr_q[k+1];
        bank_d[k] = hit ? ins_bank  : bank_q[k+1];
        col_d[k]  = hit ? ins_col   : col_q[k+1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[k]  <= 1'b0;
        wr_q[k]   <= 1'b0;
        bank_q[k] <= '0;
        col_q[k]  <= '0;
      end else begin
        vld_q[k]  <= vld_d[k];
        wr_q[k]   <= wr_d[k];
        bank_q[k] <= bank_d[k];
        col_q[k]  <= col_d[k];
      end
    end
  end

  assign head_valid = vld_q[0];
  assign head_write = wr_q[0];
  assign head_bank  = bank_q[0];
  assign head_col   = col_q[0];

endmodule

// File: rtl/ddr_cmd_seq_banktmr.sv
// One row-cycle down-counter per bank; a bank is free when its counter is zero.
module ddr_cmd_seq_banktmr #(
  parameter int BANKS = 4,
  parameter int TRC_W = 6,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [TRC_W-1:0]  trc_cfg,
  input  logic [BANK_W-1:0] query_bank,
  output logic              query_free
);

  logic [TRC_W-1:0] cnt_q [BANKS];
  logic [TRC_W-1:0] cnt_d [BANKS];
  logic [TRC_W-1:0] load_val;

  assign load_val = (trc_cfg == '0) ? '0 : trc_cfg - TRC_W'(1);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic load;
    assign load = act_en && (act_bank == BANK_W'(b));

    always_comb begin
      if (load)                cnt_d[b] = load_val;
      else if (cnt_q[b] != '0) cnt_d[b] = cnt_q[b] - TRC_W'(1);
      else                     cnt_d[b] = cnt_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[b] <= '0;
      else        cnt_q[b] <= cnt_d[b];
    end
  end

  assign query_free = (cnt_q[query_bank] == '0);

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq #(
  parameter int BANKS = 4,
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TRC_W = 6,
  parameter int TRCD  = 3,
  parameter int CL    = 2,
  parameter int AL    = 2,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int LAT_W  = $clog2(AL + CL + 1),
  localparam int IDX_W  = (TRCD > 1) ? $clog2(TRCD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              posted_en,
  input  logic [TRC_W-1:0]  trc_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_autopre,
  output logic [LAT_W-1:0]  data_lat
);
  import ddr_cmd_seq_pkg::*;

  logic              col_due, col_wr;
  logic [BANK_W-1:0] col_bank;
  logic [COL_W-1:0]  col_addr;
  logic              bank_free, act_fire;
  logic [IDX_W-1:0]  ins_at;

  cmd_kind_e         kind_d, kind_q;
  logic              vld_d, vld_q, ap_d, ap_q;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [LAT_W-1:0]  lat_d, lat_q;

  // A due column command owns the next edge; activates fill the gaps.
  assign req_ready = !col_due && bank_free;
  assign act_fire  = req_valid && req_ready;
  assign ins_at    = posted_en ? '0 : IDX_W'(TRCD - 1);

  ddr_cmd_seq_colpipe #(.DEPTH(TRCD), .BANK_W(BANK_W), .COL_W(COL_W)) u_colpipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_en     (act_fire),
    .ins_at     (ins_at),
    .ins_write  (req_write),
    .ins_bank   (req_bank),
    .ins_col    (req_col),
    .head_valid (col_due),
    .head_write (col_wr),
    .head_bank  (col_bank),
    .head_col   (col_addr)
  );

  ddr_cmd_seq_banktmr #(.BANKS(BANKS), .TRC_W(TRC_W)) u_banktmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_en     (act_fire),
    .act_bank   (req_bank),
    .trc_cfg    (trc_cfg),
    .query_bank (req_bank),
    .query_free (bank_free)
  );

  always_comb begin
    vld_d  = 1'b0;
    kind_d = KIND_IDLE;
    bank_d = '0;
    addr_d = '0;
    ap_d   = 1'b0;
    lat_d  = '0;
    if (col_due) begin
      vld_d  = 1'b1;
      kind_d = col_wr ? KIND_WR : KIND_RD;
      bank_d = col_bank;
      addr_d = ADDR_W'(col_addr);
      ap_d   = 1'b1;
      lat_d  = LAT_W'(beat_delay(posted_en, col_wr, CL, AL));
    end else if (act_fire) begin
      vld_d  = 1'b1;
      kind_d = KIND_ACT;
      bank_d = req_bank;
      addr_d = ADDR_W'(req_row);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= KIND_IDLE;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      lat_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      kind_q <= kind_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
      ap_q   <= ap_d;
      lat_q  <= lat_d;
    end
  end

  assign cmd_valid   = vld_q;
  assign cmd_kind    = kind_q;
  assign cmd_bank    = bank_q;
  assign cmd_addr    = addr_q;
  assign cmd_autopre = ap_q;
  assign data_lat    = lat_q;

endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14,
  parameter int ADDR_W = 14,
  parameter int LAT_W  = 3,
  parameter int CL     = 2,
  parameter int AL     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              posted_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic              cmd_valid,
  input logic [1:0]        cmd_kind,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_autopre,
  input logic [LAT_W-1:0]  data_lat
);

  logic is_col;
  assign is_col = cmd_valid && cmd_kind[1];

  a_r2_act_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_valid && cmd_kind == 2'd1 &&
      cmd_bank == $past(req_bank) && cmd_addr == ADDR_W'($past(req_row))));

  a_r4_posted_col_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1 && posted_en) |=>
      (cmd_valid && cmd_kind[1] && cmd_bank == $past(cmd_bank)));

  a_r6_autopre_col: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> cmd_autopre);

  a_r6_no_autopre_else: assert property (@(posedge clk) disable iff (!rst_n)
    !is_col |-> !cmd_autopre);

  a_r8_read_lat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd2) |->
      data_lat == (posted_en ? LAT_W'(AL + CL) : LAT_W'(CL)));

  a_r5_idle_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_kind == 2'd0));

endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W), .CL(CL), .AL(AL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .posted_en   (posted_en),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_bank    (req_bank),
  .req_row     (req_row),
  .cmd_valid   (cmd_valid),
  .cmd_kind    (cmd_kind),
  .cmd_bank    (cmd_bank),
  .cmd_addr    (cmd_addr),
  .cmd_autopre (cmd_autopre),
  .data_lat    (data_lat)
);

// File: tb/ddr_cmd_seq_test.sv
`timescale 1ns/1ps
module ddr_cmd_seq_test;

  localparam int TRCD = 3;
  localparam int CL   = 2;
  localparam int AL   = 2;

  logic        clk, rst_n, posted_en;
  logic [5:0]  trc_cfg;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_bank;
  logic [13:0] req_row;
  logic [9:0]  req_col;
  logic        cmd_valid, cmd_autopre;
  logic [1:0]  cmd_kind, cmd_bank;
  logic [13:0] cmd_addr;
  logic [2:0]  data_lat;

  ddr_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .posted_en(posted_en), .trc_cfg(trc_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_autopre(cmd_autopre), .data_lat(data_lat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int cyc;
  bit pv [16];
  bit pw [16];
  int pb [16];
  int pc [16];
  int bfree [4];
  int e_k, e_b, e_a, e_ap, e_lat;
  int act_cyc [8];
  int act_n;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_lat(input bit posted, input bit wr);
    return CL + (posted ? AL : 0) - (wr ? 1 : 0);
  endfunction

  task automatic compare_cmd();
    string t;
    if (e_k == 1) t = "R2";
    else if (e_k >= 2) t = posted_en ? "R4" : "R3";
    else t = "R5";
    chk(int'(cmd_valid) == (e_k != 0 ? 1 : 0), {t, " valid"}, int'(cmd_valid), e_k != 0 ? 1 : 0);
    chk(int'(cmd_kind) == e_k, {t, " kind"}, int'(cmd_kind), e_k);
    if (e_k != 0) begin
      chk(int'(cmd_bank) == e_b, {t, " bank"}, int'(cmd_bank), e_b);
      chk(int'(cmd_addr) == e_a, {t, " addr"}, int'(cmd_addr), e_a);
    end
    chk(int'(cmd_autopre) == e_ap, "R6 autopre", int'(cmd_autopre), e_ap);
    chk(int'(data_lat) == e_lat, "R8 data_lat", int'(data_lat), e_lat);
  endtask

  // one cycle: drive at negedge, check ready, predict, advance, check command
  task automatic step(input bit v, input bit w, input int b, input int row, input int col,
                      output bit accepted);
    int nx, slot, d;
    bit er;
    req_valid = v; req_write = w; req_bank = 2'(b); req_row = 14'(row); req_col = 10'(col);
    #1;
    nx = (cyc + 1) % 16;
    er = !pv[nx] && (cyc + 1 >= bfree[b]);
    chk(req_ready == er, pv[nx] ? "R5 ready" : "R7 ready", int'(req_ready), int'(er));
    accepted = 0;
    e_k = 0; e_b = 0; e_a = 0; e_ap = 0; e_lat = 0;
    if (pv[nx]) begin
      e_k = pw[nx] ? 3 : 2; e_b = pb[nx]; e_a = pc[nx]; e_ap = 1;
      e_lat = exp_lat(posted_en, pw[nx]);
      pv[nx] = 0;
    end else if (v && er) begin
      d = posted_en ? 1 : TRCD;
      e_k = 1; e_b = b; e_a = row;
      slot = (cyc + 1 + d) % 16;
      pv[slot] = 1; pw[slot] = w; pb[slot] = b; pc[slot] = col;
      bfree[b] = cyc + 1 + int'(trc_cfg);
      if (act_n < 8) act_cyc[act_n] = cyc + 1;
      act_n++;
      accepted = 1;
    end
    @(posedge clk); @(negedge clk);
    cyc++;
    compare_cmd();
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, a);
  endtask

  // constant stream to banks 0..3 from idle; returns nothing, fills act_cyc
  task automatic burst4(output int start);
    bit a;
    int k;
    act_n = 0; k = 0; start = cyc;
    while (k < 4) begin
      step(1, k[0], k, 100 + k, 20 + k, a);
      if (a) k++;
    end
    idle(8);
  endtask

  initial begin
    bit a;
    int s, bank, row, col, rate;
    bit v, w, hold;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; posted_en = 1'b0; trc_cfg = 6'd1;
    req_valid = 0; req_write = 0; req_bank = 0; req_row = 0; req_col = 0;
    cyc = 0; act_n = 0;
    for (int i = 0; i < 16; i++) pv[i] = 0;
    for (int i = 0; i < 4; i++) bfree[i] = 0;
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 valid in reset", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    #1;
    chk(cmd_kind == 2'd0, "R1 kind after reset", int'(cmd_kind), 0);
    e_k = 0; e_b = 0; e_a = 0; e_ap = 0; e_lat = 0;

    // R9 legacy: activates at +1,+2,+3,+7
    burst4(s);
    chk(act_cyc[0] == s + 1, "R9 legacy act0", act_cyc[0] - s, 1);
    chk(act_cyc[1] == s + 2, "R9 legacy act1", act_cyc[1] - s, 2);
    chk(act_cyc[2] == s + 3, "R9 legacy act2", act_cyc[2] - s, 3);
    chk(act_cyc[3] == s + 7, "R9 legacy act3", act_cyc[3] - s, 7);

    // R9 posted: activates every second cycle
    posted_en = 1'b1;
    burst4(s);
    for (int i = 0; i < 4; i++)
      chk(act_cyc[i] == s + 1 + 2 * i, "R9 posted act", act_cyc[i] - s, 1 + 2 * i);

    // R7 directed: same bank back to back with a long row cycle
    trc_cfg = 6'd9;
    act_n = 0; s = cyc;
    for (int i = 0; i < 14; i++) step(1, 0, 2, 7, 3, a);
    chk(act_n >= 2 && act_cyc[1] - act_cyc[0] == 9, "R7 same bank gap",
        act_cyc[1] - act_cyc[0], 9);
    idle(12);

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      posted_en = ph[0];
      trc_cfg = 6'(1 + ($urandom % 10));
      rate = 40 + 10 * ph;
      hold = 0; v = 0; w = 0; bank = 0; row = 0; col = 0;
      for (int i = 0; i < 300; i++) begin
        if (!hold) begin
          v = ($urandom % 100) < rate;
          w = $urandom % 2;
          bank = $urandom % 4;
          row = $urandom % 16384;
          col = $urandom % 1024;
        end
        step(v, w, bank, row, col, a);
        hold = v && !a;
      end
      idle(12);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule